// File: doc/BRIEF.md
# Read Channel Mode Controller

This block picks the operating mode of a disk read channel once per clock. It looks at three gates from the disk controller: servo, read and write. It also looks at a programmable write-gate polarity bit, a direct-write control bit, an active-low direct-write pin and an active-low power-down pin. From these it drives a one-hot mode indication with five modes: idle, servo, data read, normal write and direct write. It also drives the enables that the surrounding channel logic needs: the read-data and polarity output enables, the front-end power override, and the direction of the NRZ data bus.

Priority runs servo first, then read, then write, then idle. A read gate ends any write on the next clock. After read mode ends, a guard timer holds off write entry for `GUARD_CYC` clocks, which is one NRZ byte period. A write gate that arrives during the guard is not lost. It takes effect as soon as the guard expires. All outputs are registered, so they change one clock after the inputs that cause the change.

Top module: `rc_mode_ctrl`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, and at all times, exactly one of the five mode outputs is high. Reset selects idle.
- R2: In idle, `rdata_en`, `pol_en`, `fe_force_on`, `nrz_drive` and `nrz_sample` are all low. This means the NRZ bus is tri-stated.
- R3: A high `servo_gate` selects servo mode whatever the other inputs are, including power-down. Servo mode sets `rdata_en`, `pol_en` and `fe_force_on` high and leaves both NRZ direction controls low.
- R4: With servo low, a high `read_gate` selects data read mode, even when a write is in progress. Data read mode sets `rdata_en`, `pol_en` and `nrz_drive` high.
- R5: The write gate is active when `write_gate` equals `wg_pol_high`. With `wg_pol_high`=1 it is active high; with `wg_pol_high`=0 it is active low.
- R6: Normal write is selected when the write gate is active and all of the following hold: `dw_pin_n`=1, `dw_ctrl`=0, `pwr_dn_n`=1, no guard is pending, and servo and read are both low.
- R7: Under the same conditions, but with `dw_pin_n`=0 or `dw_ctrl`=1, direct write is selected instead of normal write.
- R8: After the first clock edge at which `read_gate` is sampled low, no write mode is entered for `GUARD_CYC` clock edges. This includes that first edge.
- R9: If the write gate stays active through the guard, write mode is entered at the edge right after the guard ends, so the gate is held off rather than dropped.
- R10: While `pwr_dn_n` is low, neither write mode is entered. Servo, read and idle selection still work.
- R11: In both write modes `nrz_sample` is high and `nrz_drive` is low. The two are never high together.
- R12: Every output is registered. It reflects the inputs sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| servo_gate | input | 1 | Servo gate, active high |
| read_gate | input | 1 | Read gate, active high |
| write_gate | input | 1 | Write gate, level set by `wg_pol_high` |
| wg_pol_high | input | 1 | Write gate polarity: 1 active high, 0 active low |
| dw_ctrl | input | 1 | Direct-write control bit, 1 requests direct write |
| dw_pin_n | input | 1 | Direct-write pin, active low |
| pwr_dn_n | input | 1 | Power-down pin, low blocks writes |
| mode_idle | output | 1 | Idle mode |
| mode_servo | output | 1 | Servo mode |
| mode_read | output | 1 | Data read mode |
| mode_nwrite | output | 1 | Normal write mode |
| mode_dwrite | output | 1 | Direct write mode |
| rdata_en | output | 1 | Read-data output enable |
| pol_en | output | 1 | Polarity output enable |
| fe_force_on | output | 1 | Front-end power-down override (servo) |
| nrz_drive | output | 1 | NRZ bus driven outward (read) |
| nrz_sample | output | 1 | NRZ bus taken as input (write) |

## Verification
The hardest situation to reach from the ports is a write gate that stays active while the guard runs after a read. The bench must see write held off for exactly `GUARD_CYC` edges and then entered on the next edge. To get there, the bench raises read gate with the write gate already active, so the design is in read mode with a write pending. It then drops read gate and checks the mode at every edge until write appears. It repeats this with power-down held low past the guard end, to show that the release of power-down alone triggers entry. A full sweep over all 128 combinations of the seven control inputs checks the priority decode. Between vectors the bench lets the guard drain so that no vector inherits a pending guard.

// File: rtl/rc_mode_pkg.sv
package rc_mode_pkg;

  typedef enum logic [4:0] {
    RC_IDLE   = 5'b00001,
    RC_SERVO  = 5'b00010,
    RC_READ   = 5'b00100,
    RC_NWRITE = 5'b01000,
    RC_DWRITE = 5'b10000
  } rc_mode_e;

endpackage

// File: rtl/rc_wg_qualify.sv
module rc_wg_qualify (
  input  logic write_gate,
  input  logic wg_pol_high,
  output logic wg_active
);
  // Gate counts as active when it sits at the programmed level.
  always_comb wg_active = (write_gate == wg_pol_high);
endmodule

// File: rtl/rc_guard_timer.sv
module rc_guard_timer #(
  parameter int GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_gate,
  output logic write_ok
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GUARD_CYC);

  logic [CW-1:0] cnt_q;

  // Reloaded while read is high, drains to zero once read drops.
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (read_gate)        cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  always_comb write_ok = !read_gate && (cnt_q == '0);
endmodule

// File: rtl/rc_mode_arbiter.sv
module rc_mode_arbiter
  import rc_mode_pkg::*;
(
  input  logic     servo_gate,
  input  logic     read_gate,
  input  logic     wg_active,
  input  logic     write_ok,
  input  logic     pwr_dn_n,
  input  logic     dw_ctrl,
  input  logic     dw_pin_n,
  output rc_mode_e next_mode
);
  logic direct_req;

  always_comb begin
    direct_req = dw_ctrl || !dw_pin_n;
    if (servo_gate)                               next_mode = RC_SERVO;
    else if (read_gate)                           next_mode = RC_READ;
    else if (wg_active && write_ok && pwr_dn_n)   next_mode = direct_req ? RC_DWRITE : RC_NWRITE;
    else                                          next_mode = RC_IDLE;
  end
endmodule

// File: rtl/rc_mode_ctrl.sv
module rc_mode_ctrl
  import rc_mode_pkg::*;
#(
  parameter int GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic servo_gate,
  input  logic read_gate,
  input  logic write_gate,
  input  logic wg_pol_high,
  input  logic dw_ctrl,
  input  logic dw_pin_n,
  input  logic pwr_dn_n,
  output logic mode_idle,
  output logic mode_servo,
  output logic mode_read,
  output logic mode_nwrite,
  output logic mode_dwrite,
  output logic rdata_en,
  output logic pol_en,
  output logic fe_force_on,
  output logic nrz_drive,
  output logic nrz_sample
);
  logic     wg_active;
  logic     write_ok;
  rc_mode_e next_mode;
  rc_mode_e mode_q;

  rc_wg_qualify u_wgq (
    .write_gate  (write_gate),
    .wg_pol_high (wg_pol_high),
    .wg_active   (wg_active)
  );

  rc_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .read_gate (read_gate),
    .write_ok  (write_ok)
  );

  rc_mode_arbiter u_arb (
    .servo_gate (servo_gate),
    .read_gate  (read_gate),
    .wg_active  (wg_active),
    .write_ok   (write_ok),
    .pwr_dn_n   (pwr_dn_n),
    .dw_ctrl    (dw_ctrl),
    .dw_pin_n   (dw_pin_n),
    .next_mode  (next_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= RC_IDLE;
    else        mode_q <= next_mode;
  end

  always_comb begin
    mode_idle   = mode_q[0];
    mode_servo  = mode_q[1];
    mode_read   = mode_q[2];
    mode_nwrite = mode_q[3];
    mode_dwrite = mode_q[4];
    rdata_en    = mode_q[1] | mode_q[2];
    pol_en      = mode_q[1] | mode_q[2];
    fe_force_on = mode_q[1];
    nrz_drive   = mode_q[2];
    nrz_sample  = mode_q[3] | mode_q[4];
  end
endmodule

// File: rtl/rc_mode_checker.sv
module rc_mode_checker (
  input logic clk,
  input logic rst_n,
  input logic servo_gate,
  input logic read_gate,
  input logic write_gate,
  input logic wg_pol_high,
  input logic pwr_dn_n,
  input logic mode_idle,
  input logic mode_servo,
  input logic mode_read,
  input logic mode_nwrite,
  input logic mode_dwrite,
  input logic nrz_drive,
  input logic nrz_sample
);
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mode_idle, mode_servo, mode_read, mode_nwrite, mode_dwrite}) == 1); // R1
  AST_SERVO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    servo_gate |=> mode_servo); // R3
  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!servo_gate && read_gate) |=> mode_read); // R4
  AST_WG_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (write_gate != wg_pol_high) |=> !(mode_nwrite || mode_dwrite)); // R5
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mode_read |=> !(mode_nwrite || mode_dwrite)); // R8
  AST_PWRDN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> !(mode_nwrite || mode_dwrite)); // R10
  AST_NRZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nrz_drive && nrz_sample)); // R11
endmodule

bind rc_mode_ctrl rc_mode_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .servo_gate  (servo_gate),
  .read_gate   (read_gate),
  .write_gate  (write_gate),
  .wg_pol_high (wg_pol_high),
  .pwr_dn_n    (pwr_dn_n),
  .mode_idle   (mode_idle),
  .mode_servo  (mode_servo),
  .mode_read   (mode_read),
  .mode_nwrite (mode_nwrite),
  .mode_dwrite (mode_dwrite),
  .nrz_drive   (nrz_drive),
  .nrz_sample  (nrz_sample)
);

// File: tb/tb_rc_mode_ctrl.sv
`timescale 1ns/1ps
module tb_rc_mode_ctrl;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n, sg, rg, wg, pol, dwc, dwp_n, pd_n;
  logic m_idle, m_servo, m_read, m_nw, m_dw;
  logic rd_en, pl_en, fe_on, nz_drv, nz_smp;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rc_mode_ctrl #(.GUARD_CYC(G)) dut (
    .clk(clk), .rst_n(rst_n), .servo_gate(sg), .read_gate(rg), .write_gate(wg),
    .wg_pol_high(pol), .dw_ctrl(dwc), .dw_pin_n(dwp_n), .pwr_dn_n(pd_n),
    .mode_idle(m_idle), .mode_servo(m_servo), .mode_read(m_read),
    .mode_nwrite(m_nw), .mode_dwrite(m_dw), .rdata_en(rd_en), .pol_en(pl_en),
    .fe_force_on(fe_on), .nrz_drive(nz_drv), .nrz_sample(nz_smp)
  );

  // mode code: bit0 idle, 1 servo, 2 read, 3 normal write, 4 direct write
  function automatic logic [4:0] exp_mode(logic s, logic r, logic w, logic p,
                                          logic dc, logic dp, logic pd);
    if (s)                     return 5'b00010;
    if (r)                     return 5'b00100;
    if ((w == p) && pd)        return (dc || !dp) ? 5'b10000 : 5'b01000;
    return 5'b00001;
  endfunction

  // enables: {rdata_en, pol_en, fe_force_on, nrz_drive, nrz_sample}
  function automatic logic [4:0] exp_en(logic [4:0] m);
    case (m)
      5'b00010: return 5'b11100;
      5'b00100: return 5'b11010;
      5'b01000, 5'b10000: return 5'b00001;
      default:  return 5'b00000;
    endcase
  endfunction

  task automatic check(string req, logic [4:0] em);
    logic [4:0] gm, ge;
    gm = {m_dw, m_nw, m_read, m_servo, m_idle};
    ge = {rd_en, pl_en, fe_on, nz_drv, nz_smp};
    checks++;
    if (gm !== em || ge !== exp_en(em)) begin
      errors++;
      $display("FAIL %s: mode=%b en=%b expected mode=%b en=%b", req, gm, ge, em, exp_en(em));
    end
  endtask

  task automatic quiet(int n);
    sg = 0; rg = 0; wg = ~pol; dwc = 0; dwp_n = 1; pd_n = 1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sg = 1; rg = 1; wg = 1; pol = 1; dwc = 0; dwp_n = 1; pd_n = 1;
    repeat (3) @(negedge clk);
    check("R1 reset idle", 5'b00001);
    rst_n = 1;
    quiet(G + 2);
    check("R2 idle enables", 5'b00001);

    // Full sweep of the seven control inputs with a drained guard.
    for (int v = 0; v < 128; v++) begin
      logic [4:0] em;
      {sg, rg, wg, pol, dwc, dwp_n, pd_n} = 7'(v);
      em = exp_mode(sg, rg, wg, pol, dwc, dwp_n, pd_n);
      @(negedge clk);
      if (sg)            check("R3 servo priority", em);
      else if (rg)       check("R4 read priority", em);
      else if (!pd_n)    check("R10 power-down", em);
      else if (em[4])    check("R7 direct write", em);
      else if (em[3])    check("R6 normal write R11", em);
      else               check("R5 polarity idle", em);
      quiet(G + 2);
    end

    // R12: outputs hold between edges, move at the next one.
    pol = 1; wg = 1; @(negedge clk);
    check("R6 write entry", 5'b01000);
    sg = 1; #1;
    check("R12 held before edge", 5'b01000);
    @(negedge clk);
    check("R12 after edge servo", 5'b00010);

    // R4: read aborts an active write.
    quiet(G + 2); pol = 0; wg = 0; @(negedge clk);
    check("R5 active-low write", 5'b01000);
    rg = 1; @(negedge clk);
    check("R4 read aborts write", 5'b00100);

    // R8/R9: guard after read with write held active.
    rg = 0;
    for (int i = 1; i <= G; i++) begin
      @(negedge clk);
      check("R8 guard holds off write", 5'b00001);
    end
    @(negedge clk);
    check("R9 write after guard", 5'b01000);

    // Direct write held through guard, power-down past guard end.
    rg = 1; dwp_n = 0; @(negedge clk);
    check("R4 read mode", 5'b00100);
    rg = 0; pd_n = 0;
    for (int i = 1; i <= G + 3; i++) begin
      @(negedge clk);
      check("R10 no write while powered down", 5'b00001);
    end
    pd_n = 1; @(negedge clk);
    check("R7 direct write after release", 5'b10000);

    // Servo ignores power-down and pending guard.
    rg = 1; @(negedge clk); rg = 0; sg = 1; pd_n = 0; @(negedge clk);
    check("R3 servo during guard", 5'b00010);

    // Reset mid-operation.
    rst_n = 0; @(negedge clk);
    check("R1 reset from servo", 5'b00001);
    rst_n = 1; quiet(1);
    check("R2 idle after reset", 5'b00001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule